// File: doc/BRIEF.md
# Suspend-Mode DRAM Refresh Sequencer

This block keeps DRAM contents alive while the system sleeps and the host clock is stopped. A slow always-on real-time clock paces the refresh work. Both of its edges count as a refresh request. The strobe widths are timed by a small local oscillator that this block can switch off. The oscillator is modelled as a clock input, `osc_clk_i`, and the oscillator gates it with `osc_en_o`. The block runs entirely in the oscillator domain.

Software sets a suspend-refresh bit, `sus_ref_i`. The block keeps a synchronized shadow of that bit, and refresh runs only while the shadow is set. Once the shadow is set, a sticky suspend-status flag goes high. The strobe kind depends on two selects. With neither set, each request gets a RAS-only strobe. With `cbr_i` set, it gets a CAS-before-RAS strobe. For self-refresh-capable parts, `self_ref_i` makes the block drive the self-refresh entry sequence instead: CAS low, then RAS low. It holds that state and stops the oscillator until software clears the enable.

Top module: `srf_refresh_seq`

## Requirements
- R1: While reset is held, `ras_n_o` and `cas_n_o` are 1, `osc_en_o` is 1 and `sus_stat_o` is 0.
- R2: While enabled, every change of `rtc_clk_i`, rising or falling, produces exactly one strobe. If the block is idle, the RAS-only strobe drives `ras_n_o` low on the third oscillator rising edge after the change.
- R3: A refresh strobe holds `ras_n_o` low for exactly RAS_W oscillator cycles (default 4).
- R4: After a refresh strobe, `ras_n_o` stays high for at least GAP_W cycles (default 3) before it falls again.
- R5: A request that arrives during a strobe or its gap is held and never dropped. Its strobe starts exactly GAP_W cycles after `ras_n_o` rises.
- R6: With `cbr_i`=1, `cas_n_o` goes low one cycle before `ras_n_o` falls and rises together with `ras_n_o`. With `cbr_i`=0, `cas_n_o` stays 1 during a strobe.
- R7: Refresh follows a two-stage synchronized shadow of `sus_ref_i`. While the shadow is 0, edges of `rtc_clk_i` produce no strobe.
- R8: `sus_stat_o` rises once the shadow is set and stays 1 until reset. A strobe never occurs while it is 0.
- R9: With `self_ref_i`=1 and the shadow set, the block drives `cas_n_o` low on the first edge and `ras_n_o` low on the next edge. It then drives `osc_en_o` low while `sus_ref_i` stays 1.
- R10: Clearing `sus_ref_i` in self-refresh raises `osc_en_o` at once. `ras_n_o` rises on the third oscillator edge after that, and `cas_n_o` rises one cycle later. Edges of `rtc_clk_i` during the hold cause no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Local oscillator clock, gated by `osc_en_o` |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rtc_clk_i | input | 1 | Slow real-time clock; each edge is a request |
| sus_ref_i | input | 1 | Software suspend-refresh enable |
| self_ref_i | input | 1 | Select self-refresh hold instead of strobes |
| cbr_i | input | 1 | 1: CAS-before-RAS strobe, 0: RAS-only strobe |
| ras_n_o | output | 1 | DRAM row strobe, active low |
| cas_n_o | output | 1 | DRAM column strobe, active low |
| osc_en_o | output | 1 | Local oscillator enable |
| sus_stat_o | output | 1 | Sticky suspend-status flag |

## Verification
Each strobe's timing is predicted from the clock count at the moment the driver toggles `rtc_clk_i`, mode by mode:
- An idle RAS-only strobe starts 3 cycles after the toggle.
- A CAS-before-RAS strobe drops CAS at that point and drops RAS 1 cycle later.
- A held request starts RAS_W+GAP_W cycles after the previous start, plus 1 in CAS-before-RAS mode.

The driver queues each expected row-strobe fall with its cycle and CAS level. A monitor samples on the falling clock edge, pops the queue on every fall and measures the low width at every rise.

Self-refresh entry and exit are checked directly at the same falling edges:
- Entry is checked 1 and 2 cycles after `self_ref_i` is set.
- Exit is checked 2, 3 and 4 cycles after `sus_ref_i` clears.

Disabled windows are checked by the fact that no fall is expected, so any strobe there is reported as unexpected.

// File: rtl/srf_pkg.sv
package srf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CBR_PRE,
    ST_RAS,
    ST_GAP,
    ST_SR_CAS,
    ST_SR_HOLD,
    ST_SR_EXIT
  } srf_state_e;
endpackage

// File: rtl/srf_sync.sv
module srf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q[0] <= 1'b0;
        else         sr_q[0] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q[i] <= 1'b0;
        else         sr_q[i] <= sr_q[i-1];
    end
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/srf_req_gen.sv
module srf_req_gen #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rtc_i,
  input  logic en_i,
  output logic req_o
);
  logic rtc_s, rtc_d_q;

  srf_sync #(.STAGES(STAGES)) u_rtc_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rtc_i),
    .q_o   (rtc_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rtc_d_q <= 1'b0;
    else         rtc_d_q <= rtc_s;

  // both edges of the slow clock request a refresh
  assign req_o = (rtc_s ^ rtc_d_q) & en_i;
endmodule

// File: rtl/srf_strobe_fsm.sv
module srf_strobe_fsm
  import srf_pkg::*;
#(
  parameter int RAS_W = 4,
  parameter int GAP_W = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic en_i,
  input  logic sr_mode_i,
  input  logic cbr_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic sr_hold_o
);
  localparam int MAX_W = (RAS_W > GAP_W) ? RAS_W : GAP_W;
  localparam int CNT_W = $clog2(MAX_W + 1);
  localparam logic [CNT_W-1:0] RAS_LAST = CNT_W'(RAS_W - 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_W - 1);

  srf_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic pend_q, pend_d;
  logic cbr_q, cbr_d;
  logic ras_q, cas_q, ras_d, cas_d;
  logic avail, sr_go;

  assign avail = req_i | pend_q;
  assign sr_go = en_i & sr_mode_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cbr_d   = cbr_q;
    pend_d  = pend_q | req_i;
    unique case (state_q)
      ST_IDLE: begin
        if (sr_go) begin
          state_d = ST_SR_CAS;
        end else if (avail) begin
          state_d = cbr_i ? ST_CBR_PRE : ST_RAS;
          cbr_d   = cbr_i;
          cnt_d   = '0;
          pend_d  = 1'b0;
        end
      end
      ST_CBR_PRE: begin
        state_d = ST_RAS;
        cnt_d   = '0;
      end
      ST_RAS: begin
        if (cnt_q == RAS_LAST) begin
          state_d = ST_GAP;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt_q == GAP_LAST) begin
          if (!sr_go && avail) begin
            state_d = cbr_i ? ST_CBR_PRE : ST_RAS;
            cbr_d   = cbr_i;
            cnt_d   = '0;
            pend_d  = 1'b0;
          end else begin
            state_d = ST_IDLE;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SR_CAS:  state_d = ST_SR_HOLD;
      ST_SR_HOLD: if (!en_i) state_d = ST_SR_EXIT;
      ST_SR_EXIT: begin
        state_d = ST_GAP;
        cnt_d   = '0;
      end
      default: state_d = ST_IDLE;
    endcase
    if (state_d inside {ST_SR_CAS, ST_SR_HOLD, ST_SR_EXIT} || !en_i) pend_d = 1'b0;
  end

  always_comb begin
    ras_d = !(state_d inside {ST_RAS, ST_SR_HOLD});
    cas_d = !((state_d == ST_CBR_PRE) || (state_d == ST_RAS && cbr_d) ||
              (state_d inside {ST_SR_CAS, ST_SR_HOLD, ST_SR_EXIT}));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pend_q  <= 1'b0;
      cbr_q   <= 1'b0;
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pend_q  <= pend_d;
      cbr_q   <= cbr_d;
      ras_q   <= ras_d;
      cas_q   <= cas_d;
    end
  end

  assign ras_n_o   = ras_q;
  assign cas_n_o   = cas_q;
  assign sr_hold_o = (state_q == ST_SR_HOLD);
endmodule

// File: rtl/srf_refresh_seq.sv
module srf_refresh_seq #(
  parameter int RAS_W       = 4,
  parameter int GAP_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic osc_clk_i,
  input  logic rst_ni,
  input  logic rtc_clk_i,
  input  logic sus_ref_i,
  input  logic self_ref_i,
  input  logic cbr_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic osc_en_o,
  output logic sus_stat_o
);
  logic en_s, req, sr_hold, stat_q;

  // shadow of the software enable
  srf_sync #(.STAGES(SYNC_STAGES)) u_en_sync (
    .clk_i (osc_clk_i),
    .rst_ni(rst_ni),
    .d_i   (sus_ref_i),
    .q_o   (en_s)
  );

  srf_req_gen #(.STAGES(SYNC_STAGES)) u_req (
    .clk_i (osc_clk_i),
    .rst_ni(rst_ni),
    .rtc_i (rtc_clk_i),
    .en_i  (en_s),
    .req_o (req)
  );

  srf_strobe_fsm #(.RAS_W(RAS_W), .GAP_W(GAP_W)) u_fsm (
    .clk_i    (osc_clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req),
    .en_i     (en_s),
    .sr_mode_i(self_ref_i),
    .cbr_i    (cbr_i),
    .ras_n_o  (ras_n_o),
    .cas_n_o  (cas_n_o),
    .sr_hold_o(sr_hold)
  );

  always_ff @(posedge osc_clk_i or negedge rst_ni)
    if (!rst_ni)   stat_q <= 1'b0;
    else if (en_s) stat_q <= 1'b1;

  // raw enable wakes the oscillator so the hold can be left
  assign osc_en_o   = !(sr_hold && sus_ref_i);
  assign sus_stat_o = stat_q;
endmodule

// File: rtl/srf_refresh_chk.sv
module srf_refresh_chk #(
  parameter int RAS_W = 4,
  parameter int GAP_W = 3
) (
  input logic osc_clk_i,
  input logic rst_ni,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic sus_stat_o
);
  logic [7:0] lo_cnt, hi_cnt;

  always_ff @(posedge osc_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt <= '0;
      hi_cnt <= 8'(GAP_W);
    end else if (!ras_n_o) begin
      lo_cnt <= (lo_cnt == 8'hff) ? lo_cnt : lo_cnt + 8'd1;
      hi_cnt <= '0;
    end else begin
      lo_cnt <= '0;
      hi_cnt <= (hi_cnt == 8'hff) ? hi_cnt : hi_cnt + 8'd1;
    end
  end

  // R3
  ras_width_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) && cas_n_o |-> lo_cnt == 8'(RAS_W));

  // R4
  ras_gap_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) |-> hi_cnt >= 8'(GAP_W));

  // R6
  cas_lead_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    $fell(ras_n_o) && !cas_n_o |-> $past(!cas_n_o));

  // R8
  stat_before_strobe_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    !ras_n_o |-> sus_stat_o);

  // R10
  sr_exit_order_chk: assert property (@(posedge osc_clk_i) disable iff (!rst_ni)
    $rose(ras_n_o) && !cas_n_o |=> cas_n_o);
endmodule

bind srf_refresh_seq srf_refresh_chk #(.RAS_W(RAS_W), .GAP_W(GAP_W)) u_chk (
  .osc_clk_i (osc_clk_i),
  .rst_ni    (rst_ni),
  .ras_n_o   (ras_n_o),
  .cas_n_o   (cas_n_o),
  .sus_stat_o(sus_stat_o)
);

// File: tb/sim_srf_refresh_seq.sv
module sim_srf_refresh_seq;
  localparam int RAS_W = 4;
  localparam int GAP_W = 3;

  typedef struct {
    int cyc;
    bit cas_lo;
    int w;
  } exp_t;

  logic clk = 1'b0, osc_clk, en_lat = 1'b1;
  logic rst_ni = 1'b0, rtc = 1'b0, sus_ref = 1'b0, self_ref = 1'b0, cbr = 1'b0;
  logic ras_n, cas_n, osc_en, sus_stat;
  int cyc = 0, n_chk = 0, n_fail = 0, next_free = 0, fall_cyc = 0, cur_w = 0;
  bit done = 1'b0, prev_ras = 1'b1;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always_latch if (!clk) en_lat = osc_en;
  assign osc_clk = clk & en_lat;

  srf_refresh_seq #(.RAS_W(RAS_W), .GAP_W(GAP_W), .SYNC_STAGES(2)) u0 (
    .osc_clk_i (osc_clk),
    .rst_ni    (rst_ni),
    .rtc_clk_i (rtc),
    .sus_ref_i (sus_ref),
    .self_ref_i(self_ref),
    .cbr_i     (cbr),
    .ras_n_o   (ras_n),
    .cas_n_o   (cas_n),
    .osc_en_o  (osc_en),
    .sus_stat_o(sus_stat)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: toggle the slow clock and queue the expected strobe
  task automatic rtc_edge(input string req);
    int start;
    exp_t e;
    rtc = ~rtc;
    start = cyc + 3;
    if (start < next_free) start = next_free;
    e.cyc    = start + (cbr ? 1 : 0);
    e.cas_lo = cbr;
    e.w      = RAS_W;
    next_free = start + (cbr ? 1 : 0) + RAS_W + GAP_W;
    q.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (prev_ras && !ras_n) begin
        if (q.size() == 0) begin
          chk(1'b0, "R7 unexpected strobe", cyc, -1);
          cur_w = 0;
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(cyc == e.cyc, "R2/R5 strobe start cycle", cyc, e.cyc);
          chk(!cas_n == e.cas_lo, "R6 CAS level at RAS fall", !cas_n, e.cas_lo);
          cur_w = e.w;
        end
        fall_cyc = cyc;
      end
      if (!prev_ras && ras_n && cur_w != 0) begin
        chk(cyc - fall_cyc == cur_w, "R3 RAS low width", cyc - fall_cyc, cur_w);
        chk(cas_n == 1'b1, "R6 CAS rises with RAS", cas_n, 1);
      end
      prev_ras = ras_n;
    end
  end

  initial begin
    int falls, m;
    wait_cyc(3);
    chk(ras_n == 1 && cas_n == 1, "R1 strobes idle in reset", {ras_n, cas_n}, 3);
    chk(osc_en == 1, "R1 oscillator on in reset", osc_en, 1);
    chk(sus_stat == 0, "R1 status clear in reset", sus_stat, 0);
    rst_ni = 1'b1;
    wait_cyc(4);

    sus_ref = 1'b1;
    wait_cyc(2);
    chk(sus_stat == 0, "R8 status follows shadow delay", sus_stat, 0);
    wait_cyc(4);
    chk(sus_stat == 1, "R8 status set", sus_stat, 1);

    // R2 RAS-only, both edges
    rtc_edge("R2"); wait_cyc(20);
    rtc_edge("R2"); wait_cyc(20);
    // R5 request during strobe
    rtc_edge("R5"); wait_cyc(2);
    rtc_edge("R5"); wait_cyc(25);

    // R6 CAS-before-RAS
    cbr = 1'b1; wait_cyc(2);
    rtc_edge("R6"); wait_cyc(20);
    rtc_edge("R6"); wait_cyc(2);
    rtc_edge("R6"); wait_cyc(25);
    cbr = 1'b0; wait_cyc(2);

    // R7 disabled: no strobe
    sus_ref = 1'b0; wait_cyc(5);
    rtc_edge("R7"); void'(q.pop_back()); wait_cyc(20);
    rtc_edge("R7"); void'(q.pop_back()); wait_cyc(20);
    chk(ras_n == 1, "R7 no strobe while disabled", ras_n, 1);
    chk(sus_stat == 1, "R8 status sticky", sus_stat, 1);

    // R9 self-refresh entry
    sus_ref = 1'b1; wait_cyc(6);
    begin
      exp_t e;
      e.cyc = cyc + 2; e.cas_lo = 1'b1; e.w = 0;
      q.push_back(e);
    end
    self_ref = 1'b1;
    wait_cyc(1);
    chk(cas_n == 0 && ras_n == 1, "R9 CAS first", {ras_n, cas_n}, 2);
    wait_cyc(1);
    chk(cas_n == 0 && ras_n == 0, "R9 RAS follows", {ras_n, cas_n}, 0);
    wait_cyc(2);
    chk(osc_en == 0, "R9 oscillator off", osc_en, 0);
    rtc = ~rtc; wait_cyc(10);
    chk(ras_n == 0 && cas_n == 0, "R10 hold ignores requests", {ras_n, cas_n}, 0);

    // R10 exit
    m = cyc;
    sus_ref = 1'b0;
    #1;
    chk(osc_en == 1, "R10 oscillator wakes", osc_en, 1);
    wait_cyc(2);
    chk(ras_n == 0, "R10 RAS held two cycles", ras_n, 0);
    wait_cyc(1);
    chk(ras_n == 1 && cas_n == 0, "R10 RAS released first", {ras_n, cas_n}, 2);
    wait_cyc(1);
    chk(cas_n == 1, "R10 CAS released next", cas_n, 1);
    chk(cyc == m + 4, "R10 exit timing", cyc, m + 4);
    self_ref = 1'b0; wait_cyc(10);

    // recovery strobe
    sus_ref = 1'b1; wait_cyc(6);
    falls = q.size();
    rtc_edge("R2"); wait_cyc(20);
    chk(q.size() == falls, "R2 strobe after self-refresh", q.size(), falls);
    chk(q.size() == 0, "R2 all strobes seen", q.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule